// File: doc/BRIEF.md
# Quad-SPI Linear Read Sequencer

This block turns one memory-mapped read request into a complete fast-read transaction on a four-line serial flash bus. The request carries a byte address, a count of 32-bit words and a selector for one of two read variants. The sequencer lowers chip select and sends the opcode one bit per cycle on line 0. It then sends the address, sends the mode byte when the variant has one, idles through the dummy cycles and collects returned nibbles into 32-bit words.

Each serial clock cycle corresponds to one cycle of `clk`. The pad drives the serial clock only while `sclk_en` is high. Before the address goes out, the sequencer lowers it by x bytes (0 to 3). The value of x depends only on the variant. It is chosen so that the header bytes plus x fill a whole number of 32-bit words, which leaves the requested byte on a word boundary of the receive stream counted from chip select. The requester never sees the shift. Together with the start pulse, the sequencer tells the next stage how many leading bytes of the first word it must drop.

Top module: `qspi_linear_rd`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `cs_n`=1, `busy`=0, `sclk_en`=0, `io_oe`=0000, `rd_valid`=0 and `xfer_start`=0.
- R2: A request with `req_valid`=1 and `req_words`≠0 that is sampled while idle starts a transaction. In the next cycle `cs_n`=0 and `busy`=1, and `xfer_start` pulses for exactly that one cycle. A request seen while busy, or one with `req_words`=0, starts nothing and leaves `cs_n` high when the block is idle.
- R3: The first 8 transaction cycles send the opcode MSB first on `io_out[0]` with `io_oe`=0001. The opcode is 0xEB for `req_sel`=0 (quad address) and 0x6B for `req_sel`=1 (single-line address).
- R4: The flash address is `req_addr` − x modulo 2^24 and is sent MSB first. For `req_sel`=0 it goes out as 6 nibbles on `io_out[3:0]` (bit 3 carries the higher bit) with `io_oe`=1111. For `req_sel`=1 it goes out as 24 bits on `io_out[0]` with `io_oe`=0001.
- R5: For `req_sel`=0, the address is followed by 2 cycles carrying the mode byte 0xF0, high nibble first, with `io_oe`=1111, and then 4 dummy cycles with `io_oe`=0000. For `req_sel`=1, the address is followed directly by 8 dummy cycles with `io_oe`=0000.
- R6: x = (4 − ((header cycles / 2) mod 4)) mod 4. The header is 20 cycles for `req_sel`=0, which gives x=2, and 40 cycles for `req_sel`=1, which gives x=0. `drop_bytes` equals x while `xfer_start` is high.
- R7: The data phase lasts 8·N cycles, where N = `req_words` + (x≠0 ? 1 : 0), with `io_oe`=0000. `io_in` is sampled at the end of each data cycle. `cs_n` returns high in the cycle after the last data cycle, so the transaction lasts exactly header + 8·N cycles.
- R8: Each group of 8 data cycles forms one word. Nibble k (0..7) of the group lands in byte k/2 of `rd_data` (byte 0 = bits 7:0), in the high half when k is even. `rd_valid` is a one-cycle pulse in the cycle after the group's last nibble, that is header + 8·m + 8 cycles after the `xfer_start` cycle for word m.
- R9: `sclk_en` and `busy` are high exactly when `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial clock cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_sel | input | 1 | Read variant: 0 quad address with mode byte, 1 single-line address |
| req_addr | input | 24 | Requested byte address |
| req_words | input | 4 | Number of 32-bit words wanted (0 is ignored) |
| busy | output | 1 | Transaction in progress |
| xfer_start | output | 1 | One-cycle pulse in the first transaction cycle |
| drop_bytes | output | 2 | Leading bytes of the first word to discard (x) |
| cs_n | output | 1 | Flash chip select, active low |
| sclk_en | output | 1 | Enable for the serial clock |
| io_out | output | 4 | Values driven on the four data lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values sampled from the four data lines |
| rd_valid | output | 1 | Assembled word present on `rd_data` |
| rd_data | output | 32 | Assembled read word |

## Verification
The `xfer_start` pulse and `drop_bytes` appear in the cycle after the edge that accepts the request. Word m is due exactly header + 8·m + 8 cycles after that. Chip select rises at header + 8·N, and the bench counts that interval as the number of low-select cycles it observes. The bench stamps each falling edge with a free-running cycle count. It records the stamp at the start pulse, and the scoreboard compares every word together with its stamp offset against the value queued by the driver. A flash model, also sampling at the falling edges, decodes the opcode, address, mode byte and enables cycle by cycle, and drives data from the address it decoded.

// File: rtl/qspi_lrd_pkg.sv
package qspi_lrd_pkg;

    localparam logic [7:0] OP_QUAD_ADDR = 8'hEB;
    localparam logic [7:0] OP_QUAD_DATA = 8'h6B;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       addr_quad;
        logic [4:0] mode_cyc;
        logic [4:0] dummy_cyc;
    } rdcfg_t;

    function automatic rdcfg_t cfg_for(input logic single_addr);
        rdcfg_t c;
        if (single_addr) begin
            c.opcode    = OP_QUAD_DATA;
            c.addr_quad = 1'b0;
            c.mode_cyc  = 5'd0;
            c.dummy_cyc = 5'd8;
        end else begin
            c.opcode    = OP_QUAD_ADDR;
            c.addr_quad = 1'b1;
            c.mode_cyc  = 5'd2;
            c.dummy_cyc = 5'd4;
        end
        return c;
    endfunction

    // cycles from chip-select fall to the first data cycle
    function automatic int unsigned hdr_cycles(input rdcfg_t c, input int unsigned addr_w);
        return 8 + (c.addr_quad ? addr_w / 4 : addr_w) + 32'(c.mode_cyc) + 32'(c.dummy_cyc);
    endfunction

    // bytes to pull the address back so header + offset fills whole words
    function automatic logic [1:0] drop_for(input int unsigned hdr);
        int unsigned b;
        b = (hdr / 2) % 4;
        return 2'((4 - b) % 4);
    endfunction

endpackage

// File: rtl/qspi_lrd_ctrl.sv
module qspi_lrd_ctrl
    import qspi_lrd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_words,
    output phase_e            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic [7:0]        opcode,
    output logic              addr_quad,
    output logic [ADDR_W-1:0] faddr,
    output logic              xfer_start,
    output logic [1:0]        drop_bytes
);

    phase_e              phase_q, ph_nx;
    logic [CNT_W-1:0]    cnt_q, cnt_nx;
    rdcfg_t              cfg_q, cfg_in;
    logic [ADDR_W-1:0]   faddr_q;
    logic [LEN_W:0]      nword_q;
    logic                start_q;
    logic [1:0]          drop_q, drop_in;
    logic                accept, last;
    logic [CNT_W-1:0]    addr_m1, mode_m1, dummy_m1, data_m1;

    assign cfg_in  = cfg_for(req_sel);
    assign drop_in = drop_for(hdr_cycles(cfg_in, ADDR_W));
    assign accept  = (phase_q == PH_IDLE) && req_valid && (req_words != '0);
    assign last    = (cnt_q == '0);

    assign addr_m1  = cfg_q.addr_quad ? CNT_W'(ADDR_W / 4 - 1) : CNT_W'(ADDR_W - 1);
    assign mode_m1  = CNT_W'(cfg_q.mode_cyc) - CNT_W'(1);
    assign dummy_m1 = CNT_W'(cfg_q.dummy_cyc) - CNT_W'(1);
    assign data_m1  = CNT_W'({nword_q, 3'b000}) - CNT_W'(1);

    always_comb begin
        ph_nx  = phase_q;
        cnt_nx = cnt_q - CNT_W'(1);
        case (phase_q)
            PH_IDLE: begin
                cnt_nx = '0;
                if (accept) begin
                    ph_nx  = PH_CMD;
                    cnt_nx = CNT_W'(7);
                end
            end
            PH_CMD: if (last) begin
                ph_nx  = PH_ADDR;
                cnt_nx = addr_m1;
            end
            PH_ADDR: if (last) begin
                if (cfg_q.mode_cyc != '0) begin
                    ph_nx  = PH_MODE;
                    cnt_nx = mode_m1;
                end else if (cfg_q.dummy_cyc != '0) begin
                    ph_nx  = PH_DUMMY;
                    cnt_nx = dummy_m1;
                end else begin
                    ph_nx  = PH_DATA;
                    cnt_nx = data_m1;
                end
            end
            PH_MODE: if (last) begin
                if (cfg_q.dummy_cyc != '0) begin
                    ph_nx  = PH_DUMMY;
                    cnt_nx = dummy_m1;
                end else begin
                    ph_nx  = PH_DATA;
                    cnt_nx = data_m1;
                end
            end
            PH_DUMMY: if (last) begin
                ph_nx  = PH_DATA;
                cnt_nx = data_m1;
            end
            PH_DATA: if (last) begin
                ph_nx  = PH_IDLE;
                cnt_nx = '0;
            end
            default: begin
                ph_nx  = PH_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            faddr_q <= '0;
            nword_q <= '0;
            start_q <= 1'b0;
            drop_q  <= '0;
        end else begin
            phase_q <= ph_nx;
            cnt_q   <= cnt_nx;
            start_q <= accept;
            if (accept) begin
                cfg_q   <= cfg_in;
                faddr_q <= req_addr - ADDR_W'(drop_in);
                nword_q <= (LEN_W+1)'(req_words) + (LEN_W+1)'(drop_in != 2'd0);
                drop_q  <= drop_in;
            end
        end
    end

    assign phase      = phase_q;
    assign cnt        = cnt_q;
    assign opcode     = cfg_q.opcode;
    assign addr_quad  = cfg_q.addr_quad;
    assign faddr      = faddr_q;
    assign xfer_start = start_q;
    assign drop_bytes = drop_q;

    AST_DATA_AFTER_DUMMY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && $past(phase_q) != PH_DATA) |-> $past(phase_q) == PH_DUMMY); // R5

    AST_ADDR_PULLBACK: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (faddr_q + ADDR_W'(drop_q)) == $past(req_addr)); // R4

endmodule

// File: rtl/qspi_lrd_drive.sv
module qspi_lrd_drive
    import qspi_lrd_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         CNT_W     = 8,
    parameter logic [7:0] MODE_BYTE = 8'hF0
) (
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [7:0]        opcode,
    input  logic              addr_quad,
    input  logic [ADDR_W-1:0] faddr,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);

    logic [ADDR_W-1:0] nib_sh, bit_sh;

    assign nib_sh = faddr >> {cnt, 2'b00};
    assign bit_sh = faddr >> cnt;

    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        case (phase)
            PH_CMD: begin
                io_out = {3'b000, opcode[cnt[2:0]]};
                io_oe  = 4'b0001;
            end
            PH_ADDR: begin
                if (addr_quad) begin
                    io_out = nib_sh[3:0];
                    io_oe  = 4'b1111;
                end else begin
                    io_out = {3'b000, bit_sh[0]};
                    io_oe  = 4'b0001;
                end
            end
            PH_MODE: begin
                io_out = cnt[0] ? MODE_BYTE[7:4] : MODE_BYTE[3:0];
                io_oe  = 4'b1111;
            end
            default: begin
                io_out = 4'b0000;
                io_oe  = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/qspi_lrd_pack.sv
module qspi_lrd_pack
    import qspi_lrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_e      phase,
    input  logic [2:0]  cnt_lo,
    input  logic [3:0]  io_in,
    output logic        rd_valid,
    output logic [31:0] rd_data
);

    logic [31:0] acc_q, acc_nx, data_q;
    logic        valid_q;
    logic [4:0]  pos;

    // counter runs 7..0 per word: nibble k = 7 - cnt_lo, byte k/2, high half when k even
    assign pos = {~cnt_lo[2], ~cnt_lo[1], cnt_lo[0], 2'b00};

    always_comb begin
        acc_nx = acc_q;
        acc_nx[pos +: 4] = io_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (phase == PH_DATA) begin
                acc_q <= acc_nx;
                if (cnt_lo == 3'd0) begin
                    data_q  <= acc_nx;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = data_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R8

endmodule

// File: rtl/qspi_linear_rd.sv
module qspi_linear_rd
    import qspi_lrd_pkg::*;
#(
    parameter int         ADDR_W    = 24,
    parameter int         LEN_W     = 4,
    parameter logic [7:0] MODE_BYTE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_words,
    output logic              busy,
    output logic              xfer_start,
    output logic [1:0]        drop_bytes,
    output logic              cs_n,
    output logic              sclk_en,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    localparam int CNT_W = (LEN_W + 4 > $clog2(ADDR_W) + 1) ? LEN_W + 4 : $clog2(ADDR_W) + 1;

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        opcode;
    logic              addr_quad;
    logic [ADDR_W-1:0] faddr;

    qspi_lrd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .req_addr   (req_addr),
        .req_words  (req_words),
        .phase      (phase),
        .cnt        (cnt),
        .opcode     (opcode),
        .addr_quad  (addr_quad),
        .faddr      (faddr),
        .xfer_start (xfer_start),
        .drop_bytes (drop_bytes)
    );

    qspi_lrd_drive #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_BYTE(MODE_BYTE)) u_drive (
        .phase     (phase),
        .cnt       (cnt),
        .opcode    (opcode),
        .addr_quad (addr_quad),
        .faddr     (faddr),
        .io_out    (io_out),
        .io_oe     (io_oe)
    );

    qspi_lrd_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cnt_lo   (cnt[2:0]),
        .io_in    (io_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign cs_n    = (phase == PH_IDLE);
    assign sclk_en = ~cs_n;
    assign busy    = ~cs_n;

    AST_START_WITH_SELECT: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> xfer_start); // R2

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$fell(cs_n)) |-> !xfer_start); // R2

    AST_LINES_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> io_oe == 4'b0000); // R7

    AST_WORD_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!cs_n)); // R8

endmodule

// File: tb/test_qspi_linear_rd.sv
module test_qspi_linear_rd;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_sel = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_words = '0;
    logic        busy, xfer_start, cs_n, sclk_en, rd_valid;
    logic [1:0]  drop_bytes;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_starts = 0;
    int t0 = 0;
    int sclk_mis = 0;
    bit done = 0;

    // expectations for the current transaction
    logic        e_sel;
    logic [7:0]  e_cmd;
    logic [23:0] e_faddr;
    int          e_hdr, e_n, e_drop;
    logic [31:0] q_word[$];
    int          q_off[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qspi_linear_rd i_qspi_linear_rd (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_addr(req_addr), .req_words(req_words), .busy(busy),
        .xfer_start(xfer_start), .drop_bytes(drop_bytes), .cs_n(cs_n),
        .sclk_en(sclk_en), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // flash model: decodes the header itself and returns bytes from the decoded address
    int          fl_cyc = 0;
    logic [7:0]  fl_cmd, fl_mode;
    logic [23:0] fl_addr;
    int          fl_err = 0;
    always @(negedge clk) begin
        if (rst) begin
            fl_cyc = 0;
            io_in  = '0;
        end else if (!cs_n) begin
            int acy;
            acy = e_sel ? 24 : 6;
            if (fl_cyc == 0) begin
                fl_err = 0; fl_cmd = '0; fl_addr = '0; fl_mode = '0;
            end
            if (fl_cyc < 8) begin
                fl_cmd = {fl_cmd[6:0], io_out[0]};
                if (io_oe != 4'b0001) fl_err++;
            end else if (fl_cyc < 8 + acy) begin
                if (e_sel) begin
                    fl_addr = {fl_addr[22:0], io_out[0]};
                    if (io_oe != 4'b0001) fl_err++;
                end else begin
                    fl_addr = {fl_addr[19:0], io_out};
                    if (io_oe != 4'b1111) fl_err++;
                end
            end else if (fl_cyc < e_hdr) begin
                if (!e_sel && fl_cyc < 16) begin
                    fl_mode = {fl_mode[3:0], io_out};
                    if (io_oe != 4'b1111) fl_err++;
                end else if (io_oe != 4'b0000) fl_err++;
            end else begin
                int d;
                logic [7:0] b;
                d = fl_cyc - e_hdr;
                b = mem(fl_addr + 24'(d / 2));
                io_in = (d % 2 == 0) ? b[7:4] : b[3:0];
                if (io_oe != 4'b0000) fl_err++;
            end
            fl_cyc++;
        end else if (fl_cyc != 0) begin
            chk(fl_cmd == e_cmd, "R3 opcode", fl_cmd, e_cmd);
            chk(fl_addr == e_faddr, "R4 flash address", fl_addr, e_faddr);
            if (!e_sel) chk(fl_mode == 8'hF0, "R5 mode byte", fl_mode, 8'hF0);
            chk(fl_err == 0, "R5 line enables per phase", fl_err, 0);
            chk(fl_cyc == e_hdr + 8 * e_n, "R7 select length", fl_cyc, e_hdr + 8 * e_n);
            fl_cyc = 0;
            io_in  = '0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if ((sclk_en != !cs_n) || (busy != !cs_n)) sclk_mis++;
            if (xfer_start) begin
                n_starts++;
                t0 = cyc;
                chk(drop_bytes == 2'(e_drop), "R6 drop count", drop_bytes, e_drop);
            end
            if (rd_valid) begin
                if (q_word.size() == 0) begin
                    chk(0, "R8 unexpected word", rd_data, 0);
                end else begin
                    logic [31:0] w;
                    int off;
                    w = q_word.pop_front();
                    off = q_off.pop_front();
                    chk(rd_data == w, "R8 word data", rd_data, w);
                    chk(cyc - t0 == off, "R8 word timing", cyc - t0, off);
                end
            end
        end
    end

    task automatic run_req(input logic sel, input logic [23:0] addr, input int words, input bit poke);
        int starts0;
        e_sel   = sel;
        e_cmd   = sel ? 8'h6B : 8'hEB;
        e_hdr   = sel ? 40 : 20;
        e_drop  = sel ? 0 : 2;
        e_n     = words + ((e_drop != 0) ? 1 : 0);
        e_faddr = addr - 24'(e_drop);
        for (int m = 0; m < e_n; m++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) w[8*j +: 8] = mem(e_faddr + 24'(4 * m + j));
            q_word.push_back(w);
            q_off.push_back(e_hdr + 8 * m + 8);
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        starts0   = n_starts;
        req_valid = 1'b1;
        req_sel   = sel;
        req_addr  = addr;
        req_words = 4'(words);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !cs_n, "R2 busy after accept", {busy, cs_n}, 2'b10);
        if (poke) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_sel = ~sel; req_addr = ~addr; req_words = 4'd1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (!cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(n_starts == starts0 + 1, "R2 one start per request", n_starts - starts0, 1);
        chk(q_word.size() == 0, "R8 all words delivered", q_word.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !busy && !sclk_en && io_oe == 0 && !rd_valid && !xfer_start,
            "R1 state in reset", {cs_n, busy, sclk_en, io_oe, rd_valid, xfer_start}, 9'b100000000);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !busy && !sclk_en && io_oe == 0 && !rd_valid && !xfer_start,
            "R1 state after reset", {cs_n, busy, sclk_en, io_oe, rd_valid, xfer_start}, 9'b100000000);

        run_req(1'b0, 24'h001000, 1, 0);
        run_req(1'b1, 24'h123456, 3, 0);
        run_req(1'b0, 24'h000001, 2, 0);   // address wraps below zero
        run_req(1'b0, 24'hABCDEF, 15, 1);  // longest burst, request poked while busy
        run_req(1'b1, 24'hFFFFFC, 1, 0);

        // zero-length request is ignored (R2)
        begin
            int s0;
            s0 = n_starts;
            req_valid = 1'b1; req_sel = 1'b0; req_addr = 24'h000400; req_words = 4'd0;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(cs_n && !busy && n_starts == s0, "R2 zero length ignored", {cs_n, busy}, 2'b10);
        end

        chk(sclk_mis == 0, "R9 clock enable and busy follow select", sclk_mis, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule